// File: doc/BRIEF.md
# Configurable Asynchronous UART Transceiver

A full-duplex asynchronous serial port whose frame shape is set by a byte-wide mode register and whose clocking and output drive are set by a byte-wide control register. The mode register sets the data length (7, 8 or 9 bits), optional odd or even parity, and one or two stop bits. Any code outside the three data-length codes turns the port off. The control register picks which of four prescaled clock enables paces the baud generator. It also chooses push-pull or open-drain drive for the transmit line, and it returns a read-only transmitter-empty flag. The divisor from the chosen enable to the 16x oversampling tick is a fixed parameter.

Transmit data enters through a valid/ready stream into a one-word holding register. A transfer happens on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is low while the holding register is full or the port is disabled, and the source must keep `tx_valid` and `tx_data` steady until the transfer. A word loaded while a frame is in flight starts the moment the current stop bits end. Received words leave through a valid/ready stream. `rx_valid` and the result stay put until `rx_ready` is seen. A frame that completes while the previous result is still unaccepted is discarded.

The line idles high. A frame is a low start bit, then the data bits least-significant first, then the parity bit if enabled, then the high stop bits. The receiver samples at mid-bit using 16 ticks per bit.

Top module: `sercom_uart`

## Requirements
- R1: Mode bits [2:0] select the data length: 3'b100 gives 7 bits, 3'b101 gives 8 and 3'b110 gives 9. Data goes out least-significant bit first after a low start bit, and the receiver returns the same bits zero-extended in `rx_data`.
- R2: Every other value of mode bits [2:0] disables the port. In that state `tx_ready` is low, the transmit line idles high, and incoming frames produce no `rx_valid`.
- R3: Mode bit 4 set gives two stop bits, and clear gives one. A frame with 8 data bits, no parity and one stop bit is 10 bit times long. A frame with 7 data bits, parity and two stop bits is 11 bit times long.
- R4: Mode bit 6 enables a parity bit, and mode bit 5 selects even parity (1) or odd parity (0). Bit 5 has no effect on the frame while bit 6 is clear. The receiver raises `rx_perr` on a received parity mismatch.
- R5: Control bits [1:0] select the enable that paces the baud generator: 0 selects `ce_f1`, 1 selects `ce_f8`, 2 selects `ce_f32` and 3 selects `ce_fc`. One bit lasts 16*DIV pulses of the selected enable.
- R6: Control bit 3 is read-only. It reads 0 while the transmit shifter is sending and 1 once the shifter is idle. Writes to it are ignored.
- R7: After reset the mode register reads 8'h00 and the control register reads 8'h08.
- R8: With control bit 5 set, the transmit pin drives only low (`txd_oe`=1, `txd_out`=0) for a 0 bit and releases (`txd_oe`=0) for a 1 bit. With bit 5 clear, `txd_oe` stays 1.
- R9: A word accepted while a frame is being sent starts immediately after that frame's stop bits, so the start bits of back-to-back frames are exactly one frame length apart.
- R10: `rx_valid` with its data stays stable until `rx_ready`. A frame that completes while a result is still waiting is dropped.
- R11: When the first stop bit samples low, the received word is delivered with `rx_ferr` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the mode register, 1 selects the control register |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the register selected by reg_addr |
| ce_f1 | input | 1 | Prescaled clock enable, source 0 |
| ce_f8 | input | 1 | Prescaled clock enable, source 1 |
| ce_f32 | input | 1 | Prescaled clock enable, source 2 |
| ce_fc | input | 1 | Prescaled clock enable, source 3 |
| tx_data | input | 9 | Transmit word (bits above the data length ignored) |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Holding register can accept a word |
| rx_data | output | 9 | Received word, zero-extended |
| rx_perr | output | 1 | Parity mismatch on the received word |
| rx_ferr | output | 1 | First stop bit sampled low |
| rx_valid | output | 1 | Received word valid |
| rx_ready | input | 1 | Consumer accepts the received word |
| rxd | input | 1 | Serial receive line |
| txd_out | output | 1 | Transmit pin level when driven |
| txd_oe | output | 1 | Transmit pin drive enable |

## Verification
The bench times the gap between falling edges of back-to-back frames for several modes. A design that inserted an idle bit between frames, or miscounted stop or parity bits, would show a period one bit time off. The same timing under the divide-by-8 enable would expose a generator that ignored the source field. It probes the line at mid-bit to catch a reversed bit order, which a loopback alone would hide. It also injects hand-built frames with a wrong parity bit or a low stop bit, and expects the matching error flag. Other checks cover back-pressure that must drop a second frame without corrupting the held one, an inhibited mode code that must neither accept words nor report received ones, and open-drain drive that must never push the line high.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  typedef struct packed {
    logic       en;
    logic [3:0] dbits;
    logic       par_en;
    logic       par_even;
    logic       two_stop;
  } fcfg_t;

  function automatic fcfg_t decode_mode(input logic [7:0] m);
    fcfg_t c;
    c.en       = 1'b1;
    c.dbits    = 4'd8;
    case (m[2:0])
      3'b100:  c.dbits = 4'd7;
      3'b101:  c.dbits = 4'd8;
      3'b110:  c.dbits = 4'd9;
      default: c.en = 1'b0;
    endcase
    c.par_en   = m[6];
    c.par_even = m[5];
    c.two_stop = m[4];
    return c;
  endfunction

endpackage

// File: rtl/sercom_baud.sv
module sercom_baud #(
  parameter int DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ce,
  input  logic [1:0] sel,
  input  logic       run,
  output logic       tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;
  logic          pick;

  assign pick = ce[sel];
  assign tick = run && pick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (pick)      cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
  end
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx import sercom_pkg::*; #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fcfg_t             cfg,
  input  logic              tick,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              line,
  output logic              busy
);
  localparam int FW = DATA_W + 4;
  localparam int IW = $clog2(FW);
  localparam int LW = $clog2(FW + 1);

  logic [DATA_W-1:0] hold;
  logic              hold_full;
  logic [FW-1:0]     sh;
  logic [LW-1:0]     left;
  logic [3:0]        sub;
  logic [FW-1:0]     nxt_frame;
  logic [LW-1:0]     nxt_len;
  logic              par;

  always_comb begin
    par       = 1'b0;
    nxt_frame = '1;
    nxt_frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(cfg.dbits)) begin
        nxt_frame[i+1] = hold[i];
        par = par ^ hold[i];
      end
    end
    if (cfg.par_en) nxt_frame[IW'(cfg.dbits) + IW'(1)] = cfg.par_even ? par : ~par;
    nxt_len = LW'(1) + LW'(cfg.dbits) + LW'(cfg.par_en) + (cfg.two_stop ? LW'(2) : LW'(1));
  end

  assign tx_ready = cfg.en && !hold_full;
  assign line     = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; hold_full <= 1'b0; hold <= '0;
      sh <= '1; left <= '0; sub <= '0;
    end else if (!cfg.en) begin
      busy <= 1'b0; hold_full <= 1'b0; sub <= '0;
    end else begin
      if (tx_valid && tx_ready) begin
        hold <= tx_data; hold_full <= 1'b1;
      end
      if (!busy) begin
        if (hold_full) begin
          sh <= nxt_frame; left <= nxt_len; busy <= 1'b1;
          sub <= '0; hold_full <= 1'b0;
        end
      end else if (tick) begin
        sub <= sub + 4'd1;
        if (sub == 4'd15) begin
          if (left == LW'(1)) begin
            if (hold_full) begin
              sh <= nxt_frame; left <= nxt_len; hold_full <= 1'b0;
            end else begin
              busy <= 1'b0;
            end
          end else begin
            sh   <= {1'b1, sh[FW-1:1]};
            left <= left - LW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx import sercom_pkg::*; #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fcfg_t             cfg,
  input  logic              tick,
  input  logic              rxd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_valid,
  input  logic              rx_ready
);
  localparam int FW = DATA_W + 4;
  localparam int IW = $clog2(FW);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_DONE} rx_st_t;

  rx_st_t            st;
  logic              s1, s2, s_prev;
  logic [FW-1:0]     bits_q;
  logic [IW-1:0]     idx;
  logic [IW-1:0]     nb;
  logic [3:0]        sub;
  logic [DATA_W-1:0] dat;
  logic              ones, pbit, stop, perr;

  assign nb = IW'(cfg.dbits) + IW'(cfg.par_en) + IW'(1);

  always_comb begin
    dat  = '0;
    ones = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(cfg.dbits)) begin
        dat[i] = bits_q[i];
        ones = ones ^ bits_q[i];
      end
    end
    pbit = bits_q[IW'(cfg.dbits)];
    stop = bits_q[IW'(cfg.dbits) + IW'(cfg.par_en)];
    perr = cfg.par_en && (pbit != (cfg.par_even ? ones : ~ones));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; s_prev <= 1'b1;
    end else begin
      s1 <= rxd; s2 <= s1; s_prev <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= RX_IDLE; sub <= '0; idx <= '0; bits_q <= '1;
    end else if (!cfg.en) begin
      st <= RX_IDLE;
    end else begin
      case (st)
        RX_IDLE: if (s_prev && !s2) begin st <= RX_START; sub <= '0; end
        RX_START: if (tick) begin
          sub <= sub + 4'd1;
          if (sub == 4'd7) begin
            if (!s2) begin st <= RX_BITS; sub <= '0; idx <= '0; end
            else st <= RX_IDLE;
          end
        end
        RX_BITS: if (tick) begin
          sub <= sub + 4'd1;
          if (sub == 4'd15) begin
            bits_q[idx] <= s2;
            idx <= idx + IW'(1);
            if (idx == nb - IW'(1)) st <= RX_DONE;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0; rx_data <= '0; rx_perr <= 1'b0; rx_ferr <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (st == RX_DONE && (!rx_valid || rx_ready)) begin
        rx_valid <= 1'b1;
        rx_data  <= dat;
        rx_perr  <= perr;
        rx_ferr  <= !stop;
      end
    end
  end
endmodule

// File: rtl/sercom_uart.sv
module sercom_uart import sercom_pkg::*; #(
  parameter int DATA_W = 9,
  parameter int DIV    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ce_f1,
  input  logic              ce_f8,
  input  logic              ce_f32,
  input  logic              ce_fc,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_perr,
  output logic              rx_ferr,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic              rxd,
  output logic              txd_out,
  output logic              txd_oe
);
  localparam int EMPTY_BIT = 3;
  localparam int OD_BIT    = 5;
  localparam logic [7:0] CTRL_WMASK = ~(8'd1 << EMPTY_BIT);

  logic [7:0] mode_q, ctrl_q;
  fcfg_t      cfg;
  logic       tick, tx_line, tx_busy, tx_empty, od, port_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 8'h00; ctrl_q <= 8'h00;
    end else if (reg_wr) begin
      if (reg_addr) ctrl_q <= reg_wdata & CTRL_WMASK;
      else          mode_q <= reg_wdata;
    end
  end

  assign cfg      = decode_mode(mode_q);
  assign port_en  = cfg.en;
  assign od       = ctrl_q[OD_BIT];
  assign tx_empty = !tx_busy;

  always_comb begin
    reg_rdata = mode_q;
    if (reg_addr) begin
      reg_rdata = ctrl_q;
      reg_rdata[EMPTY_BIT] = tx_empty;
    end
  end

  sercom_baud #(.DIV(DIV)) u_baud (
    .clk(clk), .rst_n(rst_n), .ce({ce_fc, ce_f32, ce_f8, ce_f1}),
    .sel(ctrl_q[1:0]), .run(port_en), .tick(tick)
  );

  sercom_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .tick(tick),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .line(tx_line), .busy(tx_busy)
  );

  sercom_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .tick(tick), .rxd(rxd),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rx_valid(rx_valid), .rx_ready(rx_ready)
  );

  assign txd_out = od ? 1'b0 : tx_line;
  assign txd_oe  = od ? ~tx_line : 1'b1;
endmodule

// File: rtl/sercom_uart_chk.sv
module sercom_uart_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              od,
  input logic              tx_empty,
  input logic              txd_out,
  input logic              txd_oe,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data
);
  logic line_high;
  assign line_high = txd_oe ? txd_out : 1'b1;

  AST_DISABLED_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tx_ready); // R2
  AST_DISABLED_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> line_high); // R2
  AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> line_high); // R6
  AST_OD_DRIVES_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (od && txd_oe) |-> !txd_out); // R8
  AST_PP_ALWAYS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !od |-> txd_oe); // R8
  AST_HOLD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tx_valid && tx_ready) |=> !tx_ready); // R9
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R10
endmodule

bind sercom_uart sercom_uart_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(port_en), .od(od), .tx_empty(tx_empty),
  .txd_out(txd_out), .txd_oe(txd_oe), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
);

// File: tb/tb_sercom_uart.sv
module tb_sercom_uart;
  localparam int CLK_PERIOD = 10;
  localparam int BIT1 = 64;   // 16 ticks * DIV(4) with ce_f1

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic ce_f1 = 1'b1, ce_f8 = 1'b0, ce_f32 = 1'b0, ce_fc = 1'b0;
  logic [8:0] tx_data = '0, rx_data;
  logic tx_valid = 1'b0, tx_ready, rx_perr, rx_ferr, rx_valid, rx_ready = 1'b1;
  logic txd_out, txd_oe, rxd, line, loop_en = 1'b1, rxd_drv = 1'b1;

  int checks = 0, fails = 0, cyc = 0, pc = 0, cur_dbits = 8;
  int fall_n = 0;
  int fall_t [4];
  logic line_prev = 1'b1;

  typedef struct { logic [8:0] d; logic pe; logic fe; } exp_t;
  exp_t q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign line = txd_oe ? txd_out : 1'b1;
  assign rxd  = loop_en ? line : rxd_drv;

  sercom_uart dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ce_f1(ce_f1), .ce_f8(ce_f8), .ce_f32(ce_f32), .ce_fc(ce_fc),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rxd(rxd),
    .txd_out(txd_out), .txd_oe(txd_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    pc  <= pc + 1;
    ce_f8  <= ((pc + 1) % 8) == 0;
    ce_f32 <= ((pc + 1) % 32) == 0;
    ce_fc  <= ((pc + 1) % 3) == 0;
  end

  always @(negedge clk) begin
    if (line_prev && !line && fall_n < 4) begin
      fall_t[fall_n] = cyc;
      fall_n = fall_n + 1;
    end
    line_prev = line;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R2/R10 unexpected rx word", int'(rx_data), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rx_data == e.d && rx_perr == e.pe && rx_ferr == e.fe,
              "R1/R4/R11 rx word {data,perr,ferr}",
              int'({rx_data, rx_perr, rx_ferr}), int'({e.d, e.pe, e.fe}));
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_check(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    check(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
  endtask

  task automatic push(input logic [8:0] d, input logic pe, input logic fe);
    exp_t e;
    e.d = d & 9'((1 << cur_dbits) - 1); e.pe = pe; e.fe = fe;
    q.push_back(e);
  endtask

  task automatic send(input logic [8:0] d, input bit expect_rx);
    bit r;
    if (expect_rx) push(d, 1'b0, 1'b0);
    @(negedge clk); tx_valid = 1'b1; tx_data = d;
    forever begin
      r = tx_ready;
      @(negedge clk);
      if (r) break;
    end
    tx_valid = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raw(input logic [15:0] bits, input int n);
    loop_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      rxd_drv = bits[i];
      repeat (BIT1) @(negedge clk);
    end
    rxd_drv = 1'b1;
    settle(3 * BIT1);
    loop_en = 1'b1;
  endtask

  task automatic period(input int exp, input string tag);
    fall_n = 0;
    send(9'h0FF, 1'b1); send(9'h0FF, 1'b1); send(9'h0FF, 1'b1);
    for (int k = 0; k < 20000 && fall_n < 3; k++) @(negedge clk);
    check(fall_n >= 3 && (fall_t[2] - fall_t[1]) == exp, tag, fall_t[2] - fall_t[1], exp);
    settle(16 * BIT1 * 2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R7 reset values, R6 empty flag, R2 disabled after reset
    rd_check(1'b0, 8'h00, "R7 mode reset");
    rd_check(1'b1, 8'h08, "R7 ctrl reset (R6 empty=1)");
    check(tx_ready == 1'b0, "R2 tx_ready low when disabled", tx_ready, 0);
    check(line == 1'b1, "R2 line idle high", line, 1);

    // R1 8N1 loopback (code 101)
    wr(1'b0, 8'h05); cur_dbits = 8;
    rd_check(1'b0, 8'h05, "R7 mode readback");
    send(9'h000, 1'b1); settle(900);
    send(9'h03C, 1'b1); settle(900);
    send(9'h0A5, 1'b1); settle(900);

    // R1 LSB first: 0x01 -> bit0 high, bit1 low at mid-bit
    fall_n = 0;
    send(9'h001, 1'b1);
    for (int k = 0; k < 500 && fall_n < 1; k++) @(negedge clk);
    settle(BIT1 + BIT1/2 - 2);
    check(line == 1'b1, "R1 first data bit is LSB", line, 1);
    // R6 empty flag low during transmission
    rd_check(1'b1, 8'h00, "R6 empty flag 0 while sending");
    settle(BIT1 - 1);
    check(line == 1'b0, "R1 second data bit", line, 0);
    settle(900);
    rd_check(1'b1, 8'h08, "R6 empty flag 1 after frame");
    wr(1'b1, 8'h08);
    rd_check(1'b1, 8'h08, "R6 write to empty bit ignored");
    wr(1'b1, 8'h00);

    // R3/R9 8N1 back-to-back period: 10 bits
    period(10 * BIT1, "R9 8N1 back-to-back period");
    // R4 parity select ignored when parity disabled
    wr(1'b0, 8'h25);
    period(10 * BIT1, "R4 select bit ignored without parity");

    // R3 7 bits, even parity, two stop bits (0x74): 11 bits
    wr(1'b0, 8'h74); cur_dbits = 7;
    period(11 * BIT1, "R3 7E2 frame length");
    send(9'h1FF, 1'b1); settle(1000);
    send(9'h055, 1'b1); settle(1000);

    // R1/R4 9 bits odd parity (0x46)
    wr(1'b0, 8'h46); cur_dbits = 9;
    send(9'h1A5, 1'b1); settle(1000);
    send(9'h100, 1'b1); settle(1000);

    // R5 f8 source: 8x longer bit
    wr(1'b0, 8'h05); cur_dbits = 8;
    wr(1'b1, 8'h01);
    period(10 * BIT1 * 8, "R5 f8 source period");
    settle(12000);
    wr(1'b1, 8'h00);

    // R4 parity error injection, 8E1 (0x65): 0x55 has even parity bit 0
    wr(1'b0, 8'h65); cur_dbits = 8;
    push(9'h055, 1'b1, 1'b0);
    raw({5'h1F, 1'b1, 1'b1, 8'h55, 1'b0}, 11);
    push(9'h055, 1'b0, 1'b0);
    raw({5'h1F, 1'b1, 1'b0, 8'h55, 1'b0}, 11);

    // R11 framing error, 8N1, stop bit low
    wr(1'b0, 8'h05);
    push(9'h0A5, 1'b0, 1'b1);
    raw({6'h00, 1'b0, 8'hA5, 1'b0}, 10);
    settle(2 * BIT1);

    // R10 back-pressure: first word held, second dropped
    rx_ready = 1'b0;
    push(9'h03C, 1'b0, 1'b0);
    send(9'h03C, 1'b0); settle(900);
    check(rx_valid == 1'b1 && rx_data == 9'h03C, "R10 word held while not ready",
          int'(rx_data), 'h3C);
    send(9'h0C3, 1'b0); settle(900);
    check(rx_valid == 1'b1 && rx_data == 9'h03C, "R10 second word dropped",
          int'(rx_data), 'h3C);
    rx_ready = 1'b1;
    settle(4);
    check(rx_valid == 1'b0, "R10 valid clears after accept", rx_valid, 0);

    // R8 open drain
    wr(1'b1, 8'h20);
    settle(2);
    check(txd_oe == 1'b0, "R8 released when idle", txd_oe, 0);
    fall_n = 0;
    send(9'h0F0, 1'b1);
    for (int k = 0; k < 500 && fall_n < 1; k++) @(negedge clk);
    settle(BIT1/2);
    check(txd_oe == 1'b1 && txd_out == 1'b0, "R8 start bit pulled low",
          int'({txd_oe, txd_out}), 2);
    settle(900);
    wr(1'b1, 8'h00);
    check(txd_oe == 1'b1, "R8 push-pull drives idle", txd_oe, 1);

    // R2 inhibited code 011
    wr(1'b0, 8'h03);
    settle(4);
    check(tx_ready == 1'b0, "R2 inhibited: no tx_ready", tx_ready, 0);
    raw({6'h3F, 1'b1, 8'h5A, 1'b0}, 10);
    check(rx_valid == 1'b0 && line == 1'b1, "R2 inhibited: rx silent, line high",
          int'({rx_valid, line}), 1);

    settle(20);
    check(q.size() == 0, "R1/R10 scoreboard drained", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule